// File: doc/BRIEF.md
# Programmable LED Status Driver

This block turns a set of network status lines (link up, receive activity, transmit activity and similar) into the drive level of a single LED pin. A 16-bit control word says which status lines light the LED, whether short events are stretched to a visible length, and whether the pin is active high or active low. The LED is lit whenever at least one enabled status line is true. With stretching on, even a one-cycle event keeps the LED lit for `STRETCH_LEN` clock cycles, and each new event restarts that window.

Software changes the control word through a write port that only takes effect while an external program-enable input is high. A separate load port, used when the configuration is fetched from non-volatile storage at start-up, writes the low 16 bits whatever the program-enable level is. A read port returns the control word, padded with zeros to 32 bits, together with a live bit that shows the unstretched combined status. No data streams through the block. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure.

Control word layout: bit 15 is the live combined status (read only). Bit 14 inverts the pin. Bit 7 turns stretching on. Bits 6..0 enable status inputs 6..0, and bit 8 enables status input 7. Bits 13..9 are reserved.

Top module: `ledstat_drv`

## Requirements
- R1: The LED logical state is the OR of every status input whose enable bit is set. Input k (k = 0..6) is enabled by bit k and input 7 by bit 8. An input whose enable is clear never lights the LED, and several inputs may be enabled at once.
- R2: After a hard reset (`rst_n` low) the control word reads 0x0081 (input 0 enabled, stretching on, polarity normal), and the LED is off (`led_pin` low).
- R3: A write (`wr_en` high) while `prog_en` is low leaves the control word unchanged. With `prog_en` high the write takes effect on the next clock edge.
- R4: Read bit 15 always shows the current, unstretched OR of the enabled inputs, also while reset is applied. Writing bit 15 does not change it.
- R5: When bit 14 is set, `led_pin` is the inverse of the LED logical state, so an idle LED drives the pin high.
- R6: With bit 7 set, an enabled input that is true at a clock edge lights the LED from that edge for `STRETCH_LEN` cycles after the last such edge. A single-cycle event therefore gives exactly `STRETCH_LEN` lit cycles, and a new event restarts the count.
- R7: With bit 7 clear, the LED logical state equals the combined OR registered on the previous clock edge, with no extension. A one-cycle event gives one lit cycle.
- R8: Read bits 31..16 and 13..9 always return zero, and written values for them are discarded.
- R9: When `ld_en` is high, bits 15..0 of `ld_data` are stored in the writable fields whatever the level of `prog_en`. A load has priority over a write in the same cycle.
- R10: A soft reset (`soft_rst` high at an edge) keeps the control word and clears the stretch window and output stage, so the LED is off after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset that clears only the stretcher and output stage |
| prog_en | input | 1 | Permits register writes when high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| ld_en | input | 1 | Configuration load strobe (not gated by `prog_en`) |
| ld_data | input | 16 | Configuration load data |
| status_i | input | 8 | Status event inputs 0..7 |
| rd_data | output | 32 | Control word readback with the live status in bit 15 |
| led_pin | output | 1 | LED pin level after polarity |

## Verification
The assertions check on every cycle that gated writes leave the control word alone, that a load always lands, that a soft reset keeps the configuration and puts out the LED, that any hit lights the LED on the next edge, and that without stretching the LED equals the previous cycle's combined status. Only the bench scenarios can show the exact stretch length and its restart, the source-to-enable-bit mapping, the inverted pin level, the reserved bits reading zero, and the live status bit during reset. They do this by comparing the block against a behavioural model on every clock and by counting lit cycles after chosen pulse patterns.

// File: rtl/ledstat_pkg.sv
package ledstat_pkg;
  localparam int unsigned CTRL_W  = 16;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned NUM_SRC = 8;

  localparam int unsigned RAW_BIT = 15;
  localparam int unsigned POL_BIT = 14;
  localparam int unsigned STR_BIT = 7;

  // fields that may hold a value written or loaded
  localparam logic [CTRL_W-1:0] WR_MASK  = 16'h41FF;
  localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0081;

  // control bit that enables status source k
  function automatic int unsigned src_pos(input int unsigned k);
    return (k < 7) ? k : 8;
  endfunction
endpackage

// File: rtl/ledstat_cfg.sv
module ledstat_cfg
  import ledstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              ld_en,
  input  logic [CTRL_W-1:0] ld_data,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (ld_en) begin
      ctrl_q <= ld_data & WR_MASK;
    end else if (wr_en && prog_en) begin
      ctrl_q <= wr_data[CTRL_W-1:0] & WR_MASK;
    end
  end

  // R3: a write without program enable changes nothing
  p_gated_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !prog_en && !ld_en) |=> $stable(ctrl_q));

  // R9: a load lands regardless of program enable
  p_load_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (ctrl_q == ($past(ld_data) & WR_MASK)));
endmodule

// File: rtl/ledstat_comb.sv
module ledstat_comb
  import ledstat_pkg::*;
(
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [CTRL_W-1:0]  ctrl,
  output logic               hit
);
  logic [NUM_SRC-1:0] sel;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign sel[k] = status_i[k] & ctrl[src_pos(k)];
  end

  assign hit = |sel;
endmodule

// File: rtl/ledstat_stretch.sv
module ledstat_stretch #(
  parameter int unsigned STRETCH_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic hit,
  input  logic stretch_en,
  output logic act
);
  localparam int unsigned CW = $clog2(STRETCH_LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(STRETCH_LEN);

  logic [CW-1:0] cnt_q;
  logic          hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else if (soft_rst) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= hit;
      if (hit) begin
        cnt_q <= LEN_C;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign act = stretch_en ? (cnt_q != '0) : hold_q;

  // R6: any hit lights the LED on the next edge
  p_hit_lights_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !soft_rst) |=> act);

  // R7: without stretching the LED is the previous combined status
  p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> (stretch_en || (act == $past(hit))));

  // R10: soft reset puts the LED out
  p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !act);
endmodule

// File: rtl/ledstat_drv.sv
module ledstat_drv
  import ledstat_pkg::*;
#(
  parameter int unsigned STRETCH_LEN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               prog_en,
  input  logic               wr_en,
  input  logic [BUS_W-1:0]   wr_data,
  input  logic               ld_en,
  input  logic [CTRL_W-1:0]  ld_data,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [BUS_W-1:0]   rd_data,
  output logic               led_pin
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              hit;
  logic              act;

  ledstat_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .prog_en (prog_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ld_en   (ld_en),
    .ld_data (ld_data),
    .ctrl_q  (ctrl_q)
  );

  ledstat_comb u_comb (
    .status_i (status_i),
    .ctrl     (ctrl_q),
    .hit      (hit)
  );

  ledstat_stretch #(.STRETCH_LEN(STRETCH_LEN)) u_str (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .hit        (hit),
    .stretch_en (ctrl_q[STR_BIT]),
    .act        (act)
  );

  assign led_pin = act ^ ctrl_q[POL_BIT];
  assign rd_data = {{(BUS_W-CTRL_W){1'b0}}, hit, ctrl_q[RAW_BIT-1:0]};

  // R10: soft reset keeps the configuration
  p_cfg_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !wr_en && !ld_en) |=> $stable(ctrl_q));
endmodule

// File: tb/ledstat_drv_tb_top.sv
`timescale 1ns/100ps
module ledstat_drv_tb_top;
  localparam int LEN = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        prog_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ld_en = 1'b0;
  logic [15:0] ld_data = '0;
  logic [7:0]  status_i = '0;
  logic [31:0] rd_data;
  logic        led_pin;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ledstat_drv #(.STRETCH_LEN(LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .prog_en(prog_en),
    .wr_en(wr_en), .wr_data(wr_data), .ld_en(ld_en), .ld_data(ld_data),
    .status_i(status_i), .rd_data(rd_data), .led_pin(led_pin)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model
  logic [15:0] m_ctrl = 16'h0081;
  int          m_cnt = 0;
  bit          m_hold = 0;

  function automatic bit m_hit(input logic [15:0] c, input logic [7:0] s);
    bit h = 0;
    for (int k = 0; k < 8; k++) begin
      if (s[k] && c[(k == 7) ? 8 : k]) h = 1;
    end
    return h;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 16'h0081; m_cnt = 0; m_hold = 0;
    end else begin
      bit h;
      h = m_hit(m_ctrl, status_i);
      if (soft_rst) begin
        m_cnt = 0; m_hold = 0;
      end else begin
        m_hold = h;
        if (h) m_cnt = LEN;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
      end
      if (ld_en) m_ctrl = ld_data & 16'h41FF;
      else if (wr_en && prog_en) m_ctrl = wr_data[15:0] & 16'h41FF;
    end
  end

  always @(negedge clk) begin
    #0.5;
    if (rst_n && !done) begin
      bit a;
      logic [31:0] e;
      a = m_ctrl[7] ? (m_cnt != 0) : m_hold;
      e = {16'h0, m_hit(m_ctrl, status_i), m_ctrl[14:0]};
      chk(led_pin == (a ^ m_ctrl[14]), "R1 R5 R6 R7 led_pin vs model",
          {31'h0, led_pin}, {31'h0, a ^ m_ctrl[14]});
      chk(rd_data[15] == e[15], "R4 live status bit", rd_data, e);
      chk(rd_data[14:0] == e[14:0], "R3 R9 control readback", rd_data, e);
      chk(rd_data[31:16] == 16'h0, "R8 reserved high bits", rd_data, e);
    end
  end

  task automatic wr(input logic [31:0] d, input logic pe);
    wr_data = d; prog_en = pe; wr_en = 1'b1;
    @(negedge clk); #1;
    wr_en = 1'b0; prog_en = 1'b0;
  endtask

  task automatic ld(input logic [15:0] d);
    ld_data = d; ld_en = 1'b1;
    @(negedge clk); #1;
    ld_en = 1'b0;
  endtask

  // pulse src at iteration 0 (and at gap if gap > 0), count lit cycles
  task automatic run(input int gap, input logic [7:0] src, input logic inv,
                     output int c);
    c = 0;
    for (int i = 0; i < 40; i++) begin
      status_i = (i == 0 || (gap > 0 && i == gap)) ? src : 8'h00;
      @(negedge clk); #1;
      if (led_pin ^ inv) c++;
    end
    status_i = 8'h00;
  endtask

  initial begin
    int c;
    status_i = 8'h01;
    repeat (3) @(negedge clk);
    #1;
    chk(rd_data[15] == 1'b1, "R4 live bit during reset", rd_data, 32'h8081);
    chk(rd_data[14:0] == 15'h0081, "R2 reset control word", rd_data, 32'h8081);
    chk(led_pin == 1'b0, "R2 LED off in reset", {31'h0, led_pin}, 32'h0);
    status_i = 8'h00;
    rst_n = 1'b1;
    @(negedge clk); #1;

    run(0, 8'h01, 1'b0, c);
    chk(c == LEN, "R6 single pulse length", c, LEN);
    run(10, 8'h01, 1'b0, c);
    chk(c == LEN + 10, "R6 restart on second pulse", c, LEN + 10);
    run(0, 8'h02, 1'b0, c);
    chk(c == 0, "R1 disabled source", c, 0);

    wr(32'h0000_0000, 1'b0);
    chk(rd_data == 32'h0000_0081, "R3 gated write ignored", rd_data, 32'h81);
    wr(32'hFFFF_FFFF, 1'b1);
    chk(rd_data == 32'h0000_41FF, "R8 R3 write with reserved bits", rd_data, 32'h41FF);
    chk(led_pin == 1'b1, "R5 idle pin high when inverted", {31'h0, led_pin}, 32'h1);
    run(0, 8'h80, 1'b1, c);
    chk(c == LEN, "R5 inverted stretched pulse on source 7", c, LEN);

    wr(32'h0000_017F, 1'b1);
    run(0, 8'h80, 1'b0, c);
    chk(c == 1, "R7 no stretch one cycle", c, 1);
    run(0, 8'h40, 1'b0, c);
    chk(c == 1, "R1 source 6 via bit 6", c, 1);
    run(3, 8'h21, 1'b0, c);
    chk(c == 2, "R7 R1 two separate events", c, 2);

    wr(32'h0000_0100, 1'b1);
    run(0, 8'h7F, 1'b0, c);
    chk(c == 0, "R1 only source 7 enabled", c, 0);

    ld(16'hC081);
    chk(rd_data == 32'h0000_4081, "R9 load without program enable", rd_data, 32'h4081);
    wr_data = 32'h0000_017F; wr_en = 1'b1; prog_en = 1'b1;
    ld(16'h0002);
    wr_en = 1'b0; prog_en = 1'b0;
    chk(rd_data == 32'h0000_0002, "R9 load beats write", rd_data, 32'h2);

    status_i = 8'h02;
    #0.2;
    chk(rd_data[15] == 1'b1, "R4 live bit follows status", rd_data, 32'h8002);
    status_i = 8'h00;
    wr(32'h0000_8000, 1'b1);
    chk(rd_data == 32'h0, "R4 write to bit 15 has no effect", rd_data, 32'h0);

    ld(16'h0081);
    status_i = 8'h01;
    @(negedge clk); #1;
    status_i = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    soft_rst = 1'b1;
    @(negedge clk); #1;
    soft_rst = 1'b0;
    chk(led_pin == 1'b0, "R10 soft reset clears LED", {31'h0, led_pin}, 32'h0);
    chk(rd_data == 32'h0000_0081, "R10 soft reset keeps config", rd_data, 32'h81);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule